// File: doc/BRIEF.md
# Strap-addressed two-wire register slave

This block is the serial control port of a clock-generator register file. It watches a two-wire bus (clock and data lines), recognises bus START and STOP conditions, and answers to one 7-bit device address. The upper four address bits are fixed at `1101`. The lower three come from two three-level strap pins, which an outside sampler has already resolved to low, mid or high. When both straps read high, the port is handed over to an SPI engine that lives elsewhere. In that case this block only raises a flag and leaves the bus alone.

A bus master first writes a register pointer and then streams data bytes, and the pointer advances after each byte. For a read, the master sets the pointer in a write session, issues a repeated START and clocks bytes out. The slave only ever pulls the data line low or releases it, and never drives the clock line. The register bank holds eight bytes:
- an input-enable field that decides which of two reference inputs is active;
- a soft-reset bit;
- an interrupt flag that drives the interrupt output.

An external master-reset input restores every register to its default value.

Top module: `clkgen_ctl_slave`

## Requirements
- R1: The device address is `{4'b1101, idx[2:0]}` with `idx = 3*L(strap_hi) + L(strap_lo)`. The strap codes are 2'b00 = low (L=0), 2'b01 = mid (L=1), and 2'b10 or 2'b11 = high (L=2). The slave pulls SDA low during the ninth clock of an address byte that matches with either R/W value.
- R2: When both straps are high (idx = 8), `spi_sel` is 1. In that case the slave never pulls SDA and never writes a register, whatever the bus does.
- R3: After an address byte that does not match, the slave leaves SDA released on the ninth clock and ignores the rest of the session. No register changes.
- R4: In a write session, the byte after the address is the register pointer. Each later byte is written to the register at the pointer, and the pointer then increments. Every such byte is acknowledged. A write to a pointer of 8 or more changes nothing.
- R5: In a read session, the slave shifts out the register at the pointer MSB first and increments the pointer after each byte. It keeps sending while the master acknowledges and releases SDA after the master's NACK. A pointer of 8 or more reads as 0x00.
- R6: A STOP (SDA rising while SCL is high) ends the session at any bit, so a partly sent byte is discarded. A START (SDA falling while SCL is high) always restarts the address phase, including a repeated START inside a session.
- R7: SDA is open-drain: `sda_drive_low` only rises just after an SCL falling edge and only inside a session. SCL is an input only.
- R8: After `rst_n` is low, register i (0 to 4) holds `i*0x11`, and registers 5, 6 and 7 hold 0x00.
- R9: Writing a byte with bit 4 set to register 6 returns every register to its R8 default, and `irq` goes low.
- R10: While `mr_in` is high, every register returns to its R8 default, and `irq` is low on the following cycle.
- R11: `ref_en` follows bits [3:2] of register 5. Code 00 passes `sel_pins` through ({input1, input0}). Code 01 enables input 0 only (`ref_en` = 2'b01), 10 enables input 1 only (2'b10), and 11 enables both.
- R12: `irq` equals bit 0 of register 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus sampling is done on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| mr_in | input | 1 | Master reset, active high, restores register defaults |
| scl_in | input | 1 | Bus clock line (sensed only) |
| sda_in | input | 1 | Bus data line as seen on the wire |
| sda_drive_low | output | 1 | 1 = pull the data line low, 0 = release it |
| strap_hi | input | 2 | Resolved level of the more significant strap (00 low, 01 mid, 1x high) |
| strap_lo | input | 2 | Resolved level of the less significant strap |
| sel_pins | input | 2 | Select pins {input1, input0} used when the enable code is 00 |
| spi_sel | output | 1 | 1 when the straps hand the port to SPI |
| ref_en | output | 2 | Reference input enables {input1, input0} |
| irq | output | 1 | Interrupt output |

## Verification
The assertions assume that SDA changes while SCL is high only to form a START or a STOP. They also assume that every bus level is held for at least three system clocks so that the synchronisers see it, that the straps do not move inside a session, and that `mr_in` is a clean synchronous pulse. The bench master keeps to these limits. It holds each quarter of a bit for ten system clocks, changes data only while its clock is low, and changes the straps only between sessions, while the bus is idle.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } eng_state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_DATA
  } eng_phase_t;

  // Strap level: 00 low=0, 01 mid=1, 10/11 high=2
  function automatic logic [1:0] strap_level(input logic [1:0] code);
    logic [1:0] lvl;
    case (code)
      2'b00:   lvl = 2'd0;
      2'b01:   lvl = 2'd1;
      default: lvl = 2'd2;
    endcase
    return lvl;
  endfunction

  // Base-3 index from two straps; 8 means both high (SPI hand-over)
  function automatic logic [3:0] strap_index(input logic [1:0] hi, input logic [1:0] lo);
    logic [3:0] h, l;
    h = {2'b00, strap_level(hi)};
    l = {2'b00, strap_level(lo)};
    return (h * 4'd3) + l;
  endfunction

  function automatic logic [BYTE_W-1:0] reg_default(input int unsigned idx);
    logic [BYTE_W-1:0] v;
    if (idx < 5) v = BYTE_W'(idx * 17);
    else         v = '0;
    return v;
  endfunction

  function automatic logic [1:0] ref_enable(input logic [1:0] code, input logic [1:0] sel);
    return (code == 2'b00) ? sel : code;
  endfunction

endpackage

// File: rtl/clkctl_bus_sync.sv
module clkctl_bus_sync #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [SYNC_N-1:0] scl_ff, sda_ff;
  logic              scl_q, sda_q;
  logic              scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_N-2:0], scl_in};
      sda_ff <= {sda_ff[SYNC_N-2:0], sda_in};
      scl_q  <= scl_ff[SYNC_N-1];
      sda_q  <= sda_ff[SYNC_N-1];
    end
  end

  assign scl_s     = scl_ff[SYNC_N-1];
  assign sda_s     = sda_ff[SYNC_N-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/clkctl_byte_engine.sv
module clkctl_byte_engine
  import clkctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [6:0]        dev_addr,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_s,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_drive_low,
  output logic              wr_en,
  output logic [7:0]        ptr_o,
  output logic [BYTE_W-1:0] wr_data,
  output logic              busy
);

  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  eng_state_t        state;
  eng_phase_t        phase;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [7:0]        ptr;
  logic              rw;
  logic              mack;
  logic              byte_in_done;
  logic              bus_ok;

  assign bus_ok       = enable & ~stop_evt & ~start_evt;
  assign byte_in_done = (state == ST_RX) && scl_fall && (bitcnt == CNT_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      phase  <= PH_ADDR;
      bitcnt <= '0;
      shreg  <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
    end else if (!enable || stop_evt) begin
      state <= ST_IDLE;
    end else if (start_evt) begin
      state  <= ST_RX;
      phase  <= PH_ADDR;
      bitcnt <= '0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise && bitcnt != CNT_FULL) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end
          if (byte_in_done) begin
            case (phase)
              PH_ADDR: begin
                if (shreg[BYTE_W-1:1] == dev_addr) begin
                  rw    <= shreg[0];
                  phase <= shreg[0] ? PH_DATA : PH_PTR;
                  state <= ST_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end
              PH_PTR: begin
                ptr   <= shreg;
                phase <= PH_DATA;
                state <= ST_ACK;
              end
              default: begin
                ptr   <= ptr + 8'd1;
                state <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rw) begin
              shreg <= rd_data;
              ptr   <= ptr + 8'd1;
              state <= ST_TX;
            end else begin
              state <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == CNT_LAST) begin
              state <= ST_TXACK;
            end else begin
              shreg  <= {shreg[BYTE_W-2:0], 1'b0};
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) mack <= ~sda_s;
          if (scl_fall) begin
            if (mack) begin
              shreg  <= rd_data;
              ptr    <= ptr + 8'd1;
              bitcnt <= '0;
              state  <= ST_TX;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign wr_en         = bus_ok & byte_in_done & (phase == PH_DATA);
  assign wr_data       = shreg;
  assign ptr_o         = ptr;
  assign busy          = (state != ST_IDLE);
  assign sda_drive_low = enable &
                         ((state == ST_ACK) || ((state == ST_TX) && !shreg[BYTE_W-1]));

endmodule

// File: rtl/clkctl_reg_bank.sv
module clkctl_reg_bank
  import clkctl_pkg::*;
#(
  parameter int unsigned NREGS    = 8,
  parameter int unsigned IDS_REG  = 5,
  parameter int unsigned IDS_LSB  = 2,
  parameter int unsigned SRST_REG = 6,
  parameter int unsigned SRST_BIT = 4,
  parameter int unsigned IRQ_REG  = 7,
  parameter int unsigned IRQ_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mr_in,
  input  logic              wr_en,
  input  logic [7:0]        idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic [1:0]        ids_code,
  output logic              irq,
  output logic              soft_evt
);

  localparam int unsigned IW = $clog2(NREGS);
  localparam logic [7:0] NREG_B = 8'(NREGS);

  logic [BYTE_W-1:0] regs [NREGS];
  logic              idx_ok;

  assign idx_ok   = (idx < NREG_B);
  assign soft_evt = wr_en && (idx == 8'(SRST_REG)) && wr_data[SRST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int unsigned i = 0; i < NREGS; i++) regs[i] <= reg_default(i);
    end else if (mr_in || soft_evt) begin
      for (int unsigned i = 0; i < NREGS; i++) regs[i] <= reg_default(i);
    end else if (wr_en && idx_ok) begin
      regs[idx[IW-1:0]] <= wr_data;
    end
  end

  assign rd_data  = idx_ok ? regs[idx[IW-1:0]] : '0;
  assign ids_code = regs[IDS_REG][IDS_LSB +: 2];
  assign irq      = regs[IRQ_REG][IRQ_BIT];

endmodule

// File: rtl/clkgen_ctl_slave.sv
module clkgen_ctl_slave
  import clkctl_pkg::*;
#(
  parameter logic [3:0]  ADDR_PREFIX = 4'b1101,
  parameter int unsigned SYNC_N      = 2,
  parameter int unsigned NREGS       = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mr_in,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_drive_low,
  input  logic [1:0] strap_hi,
  input  logic [1:0] strap_lo,
  input  logic [1:0] sel_pins,
  output logic       spi_sel,
  output logic [1:0] ref_en,
  output logic       irq
);

  localparam logic [3:0] SPI_IDX = 4'd8;

  logic              sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic              wr_en, busy, soft_evt;
  logic [7:0]        ptr;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic [1:0]        ids_code;
  logic [3:0]        sidx;
  logic [6:0]        dev_addr;

  assign sidx     = strap_index(strap_hi, strap_lo);
  assign spi_sel  = (sidx == SPI_IDX);
  assign dev_addr = {ADDR_PREFIX, sidx[2:0]};

  clkctl_bus_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  clkctl_byte_engine u_eng (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (~spi_sel),
    .dev_addr      (dev_addr),
    .scl_rise      (scl_rise),
    .scl_fall      (scl_fall),
    .start_evt     (start_evt),
    .stop_evt      (stop_evt),
    .sda_s         (sda_s),
    .rd_data       (rd_data),
    .sda_drive_low (sda_drive_low),
    .wr_en         (wr_en),
    .ptr_o         (ptr),
    .wr_data       (wr_data),
    .busy          (busy)
  );

  clkctl_reg_bank #(.NREGS(NREGS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .mr_in    (mr_in),
    .wr_en    (wr_en),
    .idx      (ptr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .ids_code (ids_code),
    .irq      (irq),
    .soft_evt (soft_evt)
  );

  assign ref_en = ref_enable(ids_code, sel_pins);

endmodule

// File: rtl/clkgen_ctl_slave_chk.sv
module clkgen_ctl_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic mr_in,
  input logic spi_sel,
  input logic sda_drive_low,
  input logic irq,
  input logic busy,
  input logic stop_evt,
  input logic scl_fall,
  input logic soft_evt,
  input logic wr_en
);

  p_spi_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sel |-> !sda_drive_low);

  p_spi_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sel |-> !wr_en);

  p_stop_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !busy);

  p_pull_after_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> $past(scl_fall));

  p_pull_in_session_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sda_drive_low |-> busy);

  p_soft_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_evt |=> !irq);

  p_mr_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mr_in |=> !irq);

endmodule

bind clkgen_ctl_slave clkgen_ctl_slave_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mr_in         (mr_in),
  .spi_sel       (spi_sel),
  .sda_drive_low (sda_drive_low),
  .irq           (irq),
  .busy          (busy),
  .stop_evt      (stop_evt),
  .scl_fall      (scl_fall),
  .soft_evt      (soft_evt),
  .wr_en         (wr_en)
);

// File: tb/sim_clkgen_ctl_slave.sv
`timescale 1ns/1ps
module sim_clkgen_ctl_slave;

  localparam int Q = 10;
  localparam logic [6:0] A5 = 7'h6D;
  localparam logic [6:0] A6 = 7'h6E;
  localparam logic [6:0] A7 = 7'h6F;
  localparam logic [6:0] A0 = 7'h68;

  logic clk = 1'b0, rst_n = 1'b0, mr_in = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap_hi = 2'b01, strap_lo = 2'b10, sel_pins = 2'b10;
  logic sda_drive_low, spi_sel, irq, sda_line;
  logic [1:0] ref_en;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0, spi_pull_seen = 1'b0;
  logic [7:0] model [8];
  logic [7:0] exp_q[$], act_q[$];
  string tag_q[$];

  assign sda_line = sda_m & ~sda_drive_low;

  always #2.5 clk = ~clk;

  clkgen_ctl_slave u0 (
    .clk(clk), .rst_n(rst_n), .mr_in(mr_in), .scl_in(scl_m), .sda_in(sda_line),
    .sda_drive_low(sda_drive_low), .strap_hi(strap_hi), .strap_lo(strap_lo),
    .sel_pins(sel_pins), .spi_sel(spi_sel), .ref_en(ref_en), .irq(irq)
  );

  function automatic logic [7:0] dflt(int i);
    return (i < 5) ? 8'(i * 17) : 8'h00;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 8; i++) model[i] = dflt(i);
  endfunction

  function automatic void model_write(int idx, logic [7:0] v);
    if (idx < 8) begin
      if (idx == 6 && v[4]) model_reset();
      else model[idx] = v;
    end
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (act_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] a, e;
      string t;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(a == e, t, "read byte", a, e);
    end
  end

  always @(negedge clk) if (spi_sel && sda_drive_low) spi_pull_seen = 1'b1;

  task automatic tq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; tq(); scl_m = 1'b1; tq(); sda_m = 1'b0; tq(); scl_m = 1'b0; tq();
  endtask

  task automatic bstop();
    sda_m = 1'b0; tq(); scl_m = 1'b1; tq(); sda_m = 1'b1; tq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tq(); scl_m = 1'b1; tq(); scl_m = 1'b0;
    end
    sda_m = 1'b1; tq(); scl_m = 1'b1; tq();
    ack = !sda_line;
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tq(); scl_m = 1'b1; tq(); b[i] = sda_line; scl_m = 1'b0;
    end
    sda_m = !mack; tq(); scl_m = 1'b1; tq(); scl_m = 1'b0; tq(); sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [6:0] addr, input int ptr, input int n,
                          input logic [7:0] base, input bit exp_ack, input string req);
    bit ack;
    bstart();
    send_byte({addr, 1'b0}, ack);
    chk(ack == exp_ack, req, "address ack", ack, exp_ack);
    if (ack) begin
      send_byte(8'(ptr), ack);
      chk(ack, "R4", "pointer ack", ack, 1);
      for (int k = 0; k < n; k++) begin
        send_byte(base + 8'(k), ack);
        chk(ack, "R4", "data ack", ack, 1);
        model_write((ptr + k) & 255, base + 8'(k));
      end
    end
    bstop();
  endtask

  task automatic do_read(input logic [6:0] addr, input int ptr, input int n, input string req);
    bit ack;
    logic [7:0] b;
    bstart();
    send_byte({addr, 1'b0}, ack);
    chk(ack, req, "read setup ack", ack, 1);
    send_byte(8'(ptr), ack);
    bstart();
    send_byte({addr, 1'b1}, ack);
    chk(ack, "R1", "read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      int p;
      p = (ptr + k) & 255;
      recv_byte(k != n - 1, b);
      exp_q.push_back((p < 8) ? model[p] : 8'h00);
      tag_q.push_back(req);
      act_q.push_back(b);
    end
    bstop();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R8 / R11 / R12 reset state
    chk(sda_drive_low == 1'b0, "R7", "sda idle", sda_drive_low, 0);
    chk(irq == 1'b0, "R12", "irq reset", irq, 0);
    chk(spi_sel == 1'b0, "R2", "spi_sel reset", spi_sel, 0);
    chk(ref_en == 2'b10, "R11", "ref_en from pins", ref_en, 2);
    do_read(A5, 0, 8, "R8");

    // R4 / R5 write with auto-increment then burst read
    do_write(A5, 0, 3, 8'hA0, 1'b1, "R1");
    do_read(A5, 0, 4, "R5");

    // R11 enable codes
    do_write(A5, 5, 1, 8'h04, 1'b1, "R11");
    chk(ref_en == 2'b01, "R11", "code 01", ref_en, 1);
    do_write(A5, 5, 1, 8'h08, 1'b1, "R11");
    chk(ref_en == 2'b10, "R11", "code 10", ref_en, 2);
    do_write(A5, 5, 1, 8'h0C, 1'b1, "R11");
    chk(ref_en == 2'b11, "R11", "code 11", ref_en, 3);
    do_write(A5, 5, 1, 8'h00, 1'b1, "R11");
    sel_pins = 2'b01;
    @(negedge clk);
    chk(ref_en == 2'b01, "R11", "code 00 pins", ref_en, 1);

    // R12 interrupt flag
    do_write(A5, 7, 1, 8'h01, 1'b1, "R12");
    chk(irq == 1'b1, "R12", "irq set", irq, 1);

    // R3 wrong address ignored
    do_write(A0, 1, 1, 8'h55, 1'b0, "R3");
    do_read(A5, 1, 1, "R3");

    // R4 / R5 out-of-range pointer
    do_write(A5, 9, 1, 8'h77, 1'b1, "R4");
    do_read(A5, 7, 2, "R5");
    chk(sda_drive_low == 1'b0, "R5", "released after nack", sda_drive_low, 0);

    // R6 stop in the middle of a data byte
    begin
      bit ack;
      bstart();
      send_byte({A5, 1'b0}, ack);
      send_byte(8'd2, ack);
      for (int i = 0; i < 3; i++) begin
        sda_m = 1'b0; tq(); scl_m = 1'b1; tq(); scl_m = 1'b0;
      end
      bstop();
      chk(sda_drive_low == 1'b0, "R6", "idle after stop", sda_drive_low, 0);
    end
    do_read(A5, 2, 1, "R6");

    // R9 soft reset
    do_write(A5, 6, 1, 8'h10, 1'b1, "R9");
    chk(irq == 1'b0, "R9", "irq after soft reset", irq, 0);
    do_read(A5, 0, 8, "R9");

    // R10 master reset
    do_write(A5, 2, 1, 8'h99, 1'b1, "R10");
    do_write(A5, 7, 1, 8'h01, 1'b1, "R10");
    chk(irq == 1'b1, "R10", "irq before mr", irq, 1);
    mr_in = 1'b1;
    repeat (2) @(negedge clk);
    mr_in = 1'b0;
    model_reset();
    chk(irq == 1'b0, "R10", "irq after mr", irq, 0);
    do_read(A5, 2, 1, "R10");

    // R1 other strap combinations
    strap_hi = 2'b10; strap_lo = 2'b00;
    tq();
    do_write(A5, 3, 1, 8'h11, 1'b0, "R1");
    do_write(A6, 3, 1, 8'h3C, 1'b1, "R1");
    do_read(A6, 3, 1, "R1");
    strap_hi = 2'b11; strap_lo = 2'b01;
    tq();
    do_write(A7, 4, 1, 8'h5A, 1'b1, "R1");
    strap_hi = 2'b00; strap_lo = 2'b00;
    tq();
    do_read(A0, 4, 1, "R1");

    // R2 SPI hand-over
    strap_hi = 2'b10; strap_lo = 2'b10;
    tq();
    chk(spi_sel == 1'b1, "R2", "spi_sel", spi_sel, 1);
    do_write(A0, 0, 1, 8'hEE, 1'b0, "R2");
    chk(spi_pull_seen == 1'b0, "R2", "sda pulled in spi", spi_pull_seen, 0);
    strap_hi = 2'b01; strap_lo = 2'b10;
    tq();
    do_read(A5, 0, 1, "R2");

    repeat (20) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule